// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital controller of a 12-bit charge-redistribution successive-approximation converter. A start request while idle launches a conversion of fixed length. For each array capacitor the block drives a 2-bit switch selection that routes that capacitor to the analog input, the upper reference or the lower reference. It reads a single-bit comparator decision once per clock and builds the output code from the most significant bit down.

A conversion first spends a few clocks with every capacitor on the input, so that the comparator can balance itself at the common node. It then runs one bit trial per clock. At the close of each trial the comparator level decides whether the bit under test keeps its capacitor on the upper reference or moves it to the lower one. When the last trial closes, the block stores the code and raises a ready flag. Two enable inputs gate the upper nibble and the lower byte of the presented code. A disabled bit reads as zero, and a valid mask marks it as undriven.

Top module: `sar_seq`

## Requirements
- R1: When `start` is high at a rising edge while the block is idle, that edge begins cycle 1 of a conversion, and `busy` is high from then until the conversion ends.
- R2: A conversion lasts exactly 15 clocks. `ready` rises at the 15th rising edge after the edge that accepted `start`.
- R3: During cycles 1, 2 and 3, every 2-bit switch field of `sw` holds 10 (analog input). Field i occupies `sw[2i+1:2i]`.
- R4: During cycle 4, the bit 11 field holds 01 (upper reference) and every other field holds 00 (lower reference).
- R5: During cycle c (4 to 15), the bit under test is 15-c, and its field holds 01. Each higher bit holds 01 if its earlier decision was 1 and 00 if it was 0. Each lower bit holds 00. The decision for a bit is 1 exactly when `comp` is high at the edge that ends its cycle.
- R6: Code 11 never appears in any switch field. While idle, every field holds 00.
- R7: A `start` pulse during a conversion has no effect. The conversion ends on schedule with an unchanged result, and no second conversion follows.
- R8: `ready` and the stored code update at the edge that ends cycle 15. Both hold while idle. `ready` clears at the edge that accepts the next start. After reset, `ready` is low and the code is 0.
- R9: `oe_hi` gates bits 11:8 and `oe_lo` gates bits 7:0 of `dout`. An enabled bit shows the stored code and has `dvalid` set. A disabled bit reads 0 and has `dvalid` clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, honoured only when idle |
| comp | input | 1 | Comparator decision, high when input is at or above trial level |
| oe_hi | input | 1 | Enable for code bits 11:8 |
| oe_lo | input | 1 | Enable for code bits 7:0 |
| sw | output | 24 | Per-bit switch selection, 2 bits per capacitor (00 lower, 01 upper, 10 input) |
| busy | output | 1 | Conversion in progress |
| ready | output | 1 | Stored code is valid |
| dout | output | 12 | Gated conversion code |
| dvalid | output | 12 | Per-bit driven mask for `dout` |

## Verification
The in-RTL assertions check the following on every cycle:
- No switch field ever carries the illegal code.
- Every field stays on the input throughout the balance clocks.
- Exactly one bit is under test in each trial clock.
- The first trial is half scale.
- The cycle count advances by one regardless of a start pulse during a conversion.
- `ready` only rises after cycle 15.
- A disabled output bit never reads 1.

Only the bench scenarios can show the following:
- The final code equals the comparator model's input code across many random and edge-of-range values.
- The per-cycle trial pattern follows the binary search for a given input.
- `ready` holds its value and clears on the next start.
- A mid-conversion start leaves the result and the schedule untouched.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Switch selection per capacitor; 2'b11 is never legal.
  typedef enum logic [1:0] {
    SW_LO = 2'b00,
    SW_HI = 2'b01,
    SW_IN = 2'b10
  } sw_sel_t;

  // Reference choice for one settled or trial bit.
  function automatic sw_sel_t ref_sel(input logic bit_val);
    return bit_val ? SW_HI : SW_LO;
  endfunction
endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int BAL_CYC = 3,
  parameter int NBITS   = 12,
  localparam int TOTAL  = BAL_CYC + NBITS,
  localparam int CW     = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          accept,
  output logic          in_bal,
  output logic          enter,
  output logic          decide,
  output logic          done
);
  localparam logic [CW-1:0] BAL_C = CW'(BAL_CYC);
  localparam logic [CW-1:0] TOT_C = CW'(TOTAL);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  assign busy   = (cnt != '0);
  assign accept = start && !busy;
  assign in_bal = busy && (cnt <= BAL_C);
  assign enter  = (cnt == BAL_C);
  assign decide = (cnt > BAL_C);
  assign done   = (cnt == TOT_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (accept) cnt <= ONE_C;
    else if (done)   cnt <= '0;
    else if (busy)   cnt <= cnt + ONE_C;
  end

  // R7: a start while busy must not disturb the cycle count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (cnt == $past(cnt) + ONE_C));

  // R1: accepted start enters cycle 1
  a_r1_enter_cycle1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt == ONE_C));
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             decide,
  input  logic             comp,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] ptr,
  output logic [NBITS-1:0] settled
);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  // Keep or drop the bit under test according to the comparator.
  function automatic logic [NBITS-1:0] settle(input logic [NBITS-1:0] t,
                                              input logic [NBITS-1:0] p,
                                              input logic c);
    return c ? t : (t & ~p);
  endfunction

  assign settled = settle(trial, ptr, comp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial <= '0;
      ptr   <= '0;
    end else if (enter) begin
      trial <= MSB_ONE;
      ptr   <= MSB_ONE;
    end else if (decide) begin
      trial <= settled | (ptr >> 1);
      ptr   <= ptr >> 1;
    end
  end

  // R5: one bit under test in every trial clock
  a_r5_one_bit_tested: assert property (@(posedge clk) disable iff (!rst_n)
    decide |-> ($countones(ptr) == 1));
endmodule

// File: rtl/sar_switch.sv
module sar_switch #(
  parameter int NBITS = 12
) (
  input  logic               busy,
  input  logic               in_bal,
  input  logic [NBITS-1:0]   trial,
  output logic [2*NBITS-1:0] sw
);
  import sar_pkg::*;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    sw_sel_t sel;
    always_comb begin
      if (!busy)       sel = SW_LO;
      else if (in_bal) sel = SW_IN;
      else             sel = ref_sel(trial[i]);
    end
    assign sw[2*i +: 2] = sel;
  end
endmodule

// File: rtl/sar_outgate.sv
module sar_outgate #(
  parameter int NBITS   = 12,
  parameter int HI_BITS = 4
) (
  input  logic [NBITS-1:0] code,
  input  logic             oe_hi,
  input  logic             oe_lo,
  output logic [NBITS-1:0] dout,
  output logic [NBITS-1:0] dvalid
);
  for (genvar i = 0; i < NBITS; i++) begin : g_gate
    if (i >= NBITS - HI_BITS) begin : g_hi
      assign dvalid[i] = oe_hi;
    end else begin : g_lo
      assign dvalid[i] = oe_lo;
    end
    assign dout[i] = code[i] & dvalid[i];
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS   = 12,
  parameter int BAL_CYC = 3,
  parameter int HI_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               comp,
  input  logic               oe_hi,
  input  logic               oe_lo,
  output logic [2*NBITS-1:0] sw,
  output logic               busy,
  output logic               ready,
  output logic [NBITS-1:0]   dout,
  output logic [NBITS-1:0]   dvalid
);
  localparam int TOTAL = BAL_CYC + NBITS;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0]    TOT_C   = CW'(TOTAL);
  localparam logic [CW-1:0]    FIRST_T = CW'(BAL_CYC + 1);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  logic [CW-1:0]    cnt;
  logic             accept, in_bal, enter, decide, done;
  logic [NBITS-1:0] trial, ptr, settled, code;

  sar_timer #(.BAL_CYC(BAL_CYC), .NBITS(NBITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(cnt), .busy(busy),
    .accept(accept), .in_bal(in_bal), .enter(enter), .decide(decide), .done(done)
  );

  sar_reg #(.NBITS(NBITS)) u_reg (
    .clk(clk), .rst_n(rst_n), .enter(enter), .decide(decide), .comp(comp),
    .trial(trial), .ptr(ptr), .settled(settled)
  );

  sar_switch #(.NBITS(NBITS)) u_sw (
    .busy(busy), .in_bal(in_bal), .trial(trial), .sw(sw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      code  <= '0;
    end else if (done) begin
      ready <= 1'b1;
      code  <= settled;
    end else if (accept) begin
      ready <= 1'b0;
    end
  end

  sar_outgate #(.NBITS(NBITS), .HI_BITS(HI_BITS)) u_out (
    .code(code), .oe_hi(oe_hi), .oe_lo(oe_lo), .dout(dout), .dvalid(dvalid)
  );

  // R8: ready can only rise right after the final trial clock
  a_r8_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(cnt) == TOT_C));

  // R4: first trial is half scale
  a_r4_half_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FIRST_T) |-> (trial == MSB_ONE));

  for (genvar i = 0; i < NBITS; i++) begin : g_chk
    // R6: illegal switch code never driven
    a_r6_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      sw[2*i +: 2] != 2'b11);
    // R3: all capacitors on the input while balancing
    a_r3_balance_input: assert property (@(posedge clk) disable iff (!rst_n)
      in_bal |-> (sw[2*i +: 2] == 2'b10));
    // R9: a disabled bit never reads high
    a_r9_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dvalid[i] |-> !dout[i]);
  end
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  localparam int NB = 12;

  logic clk = 0, rst_n = 0, start = 0, oe_hi = 1, oe_lo = 1;
  logic comp;
  logic [2*NB-1:0] sw;
  logic busy, ready;
  logic [NB-1:0] dout, dvalid;
  logic [NB-1:0] vin = '0;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  int edge_q[$];

  sar_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .comp(comp),
               .oe_hi(oe_hi), .oe_lo(oe_lo), .sw(sw), .busy(busy),
               .ready(ready), .dout(dout), .dvalid(dvalid));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Comparator model: the trial level is the set of capacitors on the upper reference.
  function automatic logic [NB-1:0] level_of(input logic [2*NB-1:0] s);
    logic [NB-1:0] t;
    for (int i = 0; i < NB; i++) t[i] = (s[2*i +: 2] == 2'b01);
    return t;
  endfunction
  always_comb comp = (vin >= level_of(sw));

  // Expected switch pattern for cycle c of a conversion of code v.
  function automatic logic [2*NB-1:0] exp_sw(input int c, input int v);
    logic [2*NB-1:0] s;
    int b, t;
    if (c <= 3) begin
      for (int i = 0; i < NB; i++) s[2*i +: 2] = 2'b10;
    end else begin
      b = 15 - c;
      t = (v & ~((1 << (b + 1)) - 1)) | (1 << b);
      for (int i = 0; i < NB; i++) s[2*i +: 2] = t[i] ? 2'b01 : 2'b00;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic kick(input int code);
    @(negedge clk);
    vin = NB'(code);
    start = 1;
    exp_q.push_back(code);
    edge_q.push_back(cyc + 1);
    @(negedge clk);
    start = 0;
  endtask

  task automatic convert(input int code);
    kick(code);
    repeat (16) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard at every rising ready.
  initial begin
    bit rq = 0;
    forever begin
      @(negedge clk);
      if (ready && !rq) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected result", 1, 0);
        end else begin
          int e, s;
          e = exp_q.pop_front();
          s = edge_q.pop_front();
          check(dout == NB'(e), "R5 final code", dout, e);
          check(cyc - s == 15, "R2 conversion length", cyc - s, 15);
        end
      end
      rq = ready;
    end
  end

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !ready, "R8 reset state", {busy, ready}, 0);
    check(dout == 0, "R8 reset code", dout, 0);
    check(sw == 0, "R6 idle switches", sw, 0);
    rst_n = 1;

    // Traced conversion: per-cycle switch pattern
    kick(12'hA5C);
    for (int c = 1; c <= 15; c++) begin
      check(busy, "R1 busy during conversion", busy, 1);
      if (c <= 3)      check(sw == exp_sw(c, 12'hA5C), "R3 balance switches", sw, exp_sw(c, 12'hA5C));
      else if (c == 4) check(sw == exp_sw(c, 12'hA5C), "R4 half-scale trial", sw, exp_sw(c, 12'hA5C));
      else             check(sw == exp_sw(c, 12'hA5C), "R5 trial pattern", sw, exp_sw(c, 12'hA5C));
      @(negedge clk);
    end
    check(ready && !busy, "R8 ready at end", {ready, busy}, 2);
    check(sw == 0, "R6 idle switches after", sw, 0);

    // Corner and random codes
    convert(0);
    convert(12'hFFF);
    convert(12'h800);
    convert(12'h7FF);
    convert(1);
    for (int k = 0; k < 30; k++) convert(int'($urandom_range(0, 4095)));

    // R7: start pulse mid-conversion
    kick(12'h3C6);
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy, "R7 busy after extra start", busy, 1);
    repeat (10) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!busy && ready, "R7 no second conversion", {busy, ready}, 1);
    check(dout == 12'h3C6, "R7 result unchanged", dout, 12'h3C6);

    // R8: ready holds, then clears on next start
    repeat (5) @(negedge clk);
    check(ready && dout == 12'h3C6, "R8 ready held", dout, 12'h3C6);
    kick(12'hABC);
    check(!ready, "R8 ready cleared by start", ready, 0);
    check(busy, "R1 start accepted", busy, 1);
    repeat (16) @(negedge clk);

    // R9: output enables
    oe_hi = 0; #1;
    check(dout == 12'h0BC && dvalid == 12'h0FF, "R9 upper disabled", {dvalid, dout}, {12'h0FF, 12'h0BC});
    oe_hi = 1; oe_lo = 0; #1;
    check(dout == 12'hA00 && dvalid == 12'hF00, "R9 lower disabled", {dvalid, dout}, {12'hF00, 12'hA00});
    oe_hi = 0; #1;
    check(dout == 0 && dvalid == 0, "R9 both disabled", {dvalid, dout}, 0);
    oe_hi = 1; oe_lo = 1; #1;
    check(dout == 12'hABC && dvalid == 12'hFFF, "R9 both enabled", {dvalid, dout}, {12'hFFF, 12'hABC});

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all conversions completed", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule